// File: doc/BRIEF.md
# Key-Sequence Register Write Unlock

This block shields a small configuration register from stray software writes. A plain register bus (local byte offset, write strobe, write data, combinational read data) reaches three locations: a guarded configuration register, a read-only status register and a key data register. Software must write an exact four-byte pattern, in order, to the key data register. Only after the fourth byte does the unlock flag rise, and only while that flag is high are writes to the configuration register accepted. A single dedicated byte written to the key register locks the bank again.

The configuration register holds two control bits: an output-enable bit that takes its reset value from a strap input sampled during reset, and a reset-enable bit that resets to 1. A watchdog timeout input clears both bits whether or not the bank is unlocked. The tracker is a five-state machine. Its states are `KS_IDLE` (nothing matched), `KS_GOT1`, `KS_GOT2`, `KS_GOT3` (one, two or three bytes matched) and `KS_OPEN` (unlocked). A key write that matches the next expected byte advances one state (`KS_IDLE`→`KS_GOT1`→`KS_GOT2`→`KS_GOT3`→`KS_OPEN`). A key write that does not match, made in `KS_GOT1` to `KS_GOT3`, restarts the tracker: it goes to `KS_GOT1` if the byte is the first pattern byte, and to `KS_IDLE` otherwise. The relock byte moves `KS_OPEN`→`KS_IDLE`. Every other key byte leaves `KS_OPEN` unchanged. Synchronous reset returns any state to `KS_IDLE`.

Top module: `keyed_reg_guard`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to: `key_ok` 0, key data register (offset 0x03) 0xF3, configuration bit 0 equal to 1, configuration bit 7 equal to the value of `strap_out_en` at that edge.
- R2: Writing 0x32, 0x5D, 0x42 and then 0xAC to offset 0x03 sets `key_ok` at the clock edge that takes the fourth write. `key_ok` is also readable as bit 6 of offset 0x02.
- R3: A key write that breaks the pattern restarts the tracker, so the remaining bytes no longer unlock. If the breaking byte is 0x32, it counts as the first byte of a new attempt.
- R4: Writes to offsets other than 0x03, made between pattern bytes, do not change the progress of the tracker.
- R5: While `key_ok` is 1, writing 0x35 to offset 0x03 clears it. Any other key byte, including the full pattern again, leaves it at 1.
- R6: A write to offset 0x00 loads bit 7 into `cfg_out_en` and bit 0 into `cfg_rst_en` only while `key_ok` is 1. While `key_ok` is 0 the write is ignored and both bits keep their values.
- R7: A high `wdt_timeout` at a clock edge clears both configuration bits. It takes priority over a write made in the same cycle.
- R8: Reading offset 0x03 returns the last byte written to it, whatever the tracker does with that byte.
- R9: Offset 0x00 reads as {`cfg_out_en`, six zeros, `cfg_rst_en`}. Offset 0x02 reads as `key_ok` at bit 6 with all other bits 0. Unmapped offsets read 0x00.
- R10: A synchronous reset applied while the bank is unlocked, or partway through a pattern, relocks it and discards the partial progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Local register offset for reads and writes |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd_data | output | 8 | Combinational read data for `bus_addr` |
| strap_out_en | input | 1 | Reset value of the output-enable bit, sampled during reset |
| wdt_timeout | input | 1 | Timeout event, clears the configuration bits |
| cfg_out_en | output | 1 | Configuration bit 7 (output enable) |
| cfg_rst_en | output | 1 | Configuration bit 0 (reset enable) |
| key_ok | output | 1 | Unlock flag |

## Verification
The hardest state to reach from the ports is a pattern broken by the first pattern byte itself, with unrelated writes interleaved among the pattern bytes. The tracker must then sit in `KS_GOT1` instead of `KS_IDLE`, and the only visible effect is whether a later, shorter run of bytes unlocks the bank. The stimulus writes 0x32 twice before the rest of the pattern. In a separate pass it places writes to the locked configuration register and to unmapped offsets between pattern bytes. The status register is then read and compared: 0x40 means the restart was counted and the interleaved writes were ignored. A timeout made in the same cycle as an unlocked configuration write is also driven, to show that the timeout wins.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;

    localparam int BYTE_W  = 8;
    localparam int KEY_LEN = 4;

    localparam logic [BYTE_W-1:0] RELOCK_BYTE    = 8'h35;
    localparam logic [BYTE_W-1:0] KEY_RESET_VAL  = 8'hF3;

    typedef enum logic [2:0] {
        KS_IDLE,
        KS_GOT1,
        KS_GOT2,
        KS_GOT3,
        KS_OPEN
    } key_state_t;

    // Expected byte at each position of the unlock pattern
    function automatic logic [BYTE_W-1:0] key_byte(input int idx);
        logic [BYTE_W-1:0] b;
        case (idx)
            0:       b = 8'h32;
            1:       b = 8'h5D;
            2:       b = 8'h42;
            default: b = 8'hAC;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/key_seq_fsm.sv
module key_seq_fsm
    import keyguard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [BYTE_W-1:0] key_wdata,
    output logic              key_ok
);

    key_state_t state_q;
    key_state_t state_d;
    logic [KEY_LEN-1:0] match_vec;
    logic               relock_hit;
    key_state_t         restart_state;

    // One comparator per pattern position
    generate
        for (genvar i = 0; i < KEY_LEN; i++) begin : g_match
            assign match_vec[i] = (key_wdata == key_byte(i));
        end
    endgenerate

    assign relock_hit    = (key_wdata == RELOCK_BYTE);
    assign restart_state = match_vec[0] ? KS_GOT1 : KS_IDLE;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (key_wr) begin
            unique case (state_q)
                KS_IDLE: state_d = match_vec[0] ? KS_GOT1 : KS_IDLE;
                KS_GOT1: state_d = match_vec[1] ? KS_GOT2 : restart_state;
                KS_GOT2: state_d = match_vec[2] ? KS_GOT3 : restart_state;
                KS_GOT3: state_d = match_vec[3] ? KS_OPEN : restart_state;
                KS_OPEN: state_d = relock_hit   ? KS_IDLE : KS_OPEN;
                default: state_d = KS_IDLE;
            endcase
        end
    end

    // Output logic
    always_comb begin
        unique case (state_q)
            KS_OPEN: key_ok = 1'b1;
            default: key_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/guarded_cfg_reg.sv
module guarded_cfg_reg
    import keyguard_pkg::*;
#(
    parameter int OUT_BIT = 7,
    parameter int RST_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap,
    input  logic              wr_req,
    input  logic              unlocked,
    input  logic              timeout,
    input  logic [BYTE_W-1:0] wdata,
    output logic              out_en,
    output logic              rst_en
);

    logic wr_accept;

    assign wr_accept = wr_req & unlocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_en <= strap;
            rst_en <= 1'b1;
        end else if (timeout) begin
            out_en <= 1'b0;
            rst_en <= 1'b0;
        end else if (wr_accept) begin
            out_en <= wdata[OUT_BIT];
            rst_en <= wdata[RST_BIT];
        end
    end

endmodule

// File: rtl/reg_read_mux.sv
module reg_read_mux
    import keyguard_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CFG_OFS  = 0,
    parameter int STAT_OFS = 2,
    parameter int KEY_OFS  = 3,
    parameter int STAT_BIT = 6,
    parameter int OUT_BIT  = 7,
    parameter int RST_BIT  = 0
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              out_en,
    input  logic              rst_en,
    input  logic              key_ok,
    input  logic [BYTE_W-1:0] key_data,
    output logic [BYTE_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_OFS);

    logic [BYTE_W-1:0] cfg_word;
    logic [BYTE_W-1:0] stat_word;

    always_comb begin
        cfg_word          = '0;
        cfg_word[OUT_BIT] = out_en;
        cfg_word[RST_BIT] = rst_en;
        stat_word           = '0;
        stat_word[STAT_BIT] = key_ok;
    end

    always_comb begin
        if (rd_addr == A_CFG) begin
            rd_data = cfg_word;
        end else if (rd_addr == A_STAT) begin
            rd_data = stat_word;
        end else if (rd_addr == A_KEY) begin
            rd_data = key_data;
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/keyed_reg_guard.sv
module keyed_reg_guard
    import keyguard_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CFG_OFS  = 0,
    parameter int STAT_OFS = 2,
    parameter int KEY_OFS  = 3,
    parameter int STAT_BIT = 6,
    parameter int OUT_BIT  = 7,
    parameter int RST_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rd_data,
    input  logic              strap_out_en,
    input  logic              wdt_timeout,
    output logic              cfg_out_en,
    output logic              cfg_rst_en,
    output logic              key_ok
);

    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CFG_OFS);
    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(KEY_OFS);

    logic              key_wr;
    logic              cfg_wr;
    logic [BYTE_W-1:0] key_data_q;

    assign key_wr = bus_wr && (bus_addr == A_KEY);
    assign cfg_wr = bus_wr && (bus_addr == A_CFG);

    // Key data holding register (read/write)
    always_ff @(posedge clk) begin
        if (rst) begin
            key_data_q <= KEY_RESET_VAL;
        end else if (key_wr) begin
            key_data_q <= bus_wdata;
        end
    end

    key_seq_fsm u_seq (
        .clk       (clk),
        .rst       (rst),
        .key_wr    (key_wr),
        .key_wdata (bus_wdata),
        .key_ok    (key_ok)
    );

    guarded_cfg_reg #(
        .OUT_BIT (OUT_BIT),
        .RST_BIT (RST_BIT)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .strap    (strap_out_en),
        .wr_req   (cfg_wr),
        .unlocked (key_ok),
        .timeout  (wdt_timeout),
        .wdata    (bus_wdata),
        .out_en   (cfg_out_en),
        .rst_en   (cfg_rst_en)
    );

    reg_read_mux #(
        .ADDR_W   (ADDR_W),
        .CFG_OFS  (CFG_OFS),
        .STAT_OFS (STAT_OFS),
        .KEY_OFS  (KEY_OFS),
        .STAT_BIT (STAT_BIT),
        .OUT_BIT  (OUT_BIT),
        .RST_BIT  (RST_BIT)
    ) u_rd (
        .rd_addr  (bus_addr),
        .out_en   (cfg_out_en),
        .rst_en   (cfg_rst_en),
        .key_ok   (key_ok),
        .key_data (key_data_q),
        .rd_data  (bus_rd_data)
    );

endmodule

// File: rtl/keyguard_checker.sv
module keyguard_checker #(
    parameter int ADDR_W  = 8,
    parameter int CFG_OFS = 0,
    parameter int KEY_OFS = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              wdt_timeout,
    input logic              cfg_out_en,
    input logic              cfg_rst_en,
    input logic              key_ok,
    input logic [7:0]        key_data_q
);

    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CFG_OFS);
    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(KEY_OFS);

    logic key_write;
    logic cfg_write;
    assign key_write = bus_wr && (bus_addr == A_KEY);
    assign cfg_write = bus_wr && (bus_addr == A_CFG);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!key_ok && key_data_q == 8'hF3 && cfg_rst_en));

    p_reset_relocks_r10: assert property (@(posedge clk)
        rst |=> !key_ok);

    p_unlock_on_last_byte_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(key_ok) |-> $past(key_write && bus_wdata == 8'hAC));

    p_relock_byte_r5: assert property (@(posedge clk) disable iff (rst)
        (key_ok && key_write && bus_wdata == 8'h35) |=> !key_ok);

    p_stays_open_r5: assert property (@(posedge clk) disable iff (rst)
        (key_ok && !(key_write && bus_wdata == 8'h35)) |=> key_ok);

    p_locked_cfg_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (!key_ok && !wdt_timeout) |=> ($stable(cfg_out_en) && $stable(cfg_rst_en)));

    p_open_cfg_loads_r6: assert property (@(posedge clk) disable iff (rst)
        (key_ok && cfg_write && !wdt_timeout) |=>
            (cfg_out_en == $past(bus_wdata[7]) && cfg_rst_en == $past(bus_wdata[0])));

    p_timeout_clears_r7: assert property (@(posedge clk) disable iff (rst)
        wdt_timeout |=> (!cfg_out_en && !cfg_rst_en));

    p_key_echo_r8: assert property (@(posedge clk) disable iff (rst)
        key_write |=> (key_data_q == $past(bus_wdata)));

endmodule

bind keyed_reg_guard keyguard_checker #(
    .ADDR_W  (ADDR_W),
    .CFG_OFS (CFG_OFS),
    .KEY_OFS (KEY_OFS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .wdt_timeout (wdt_timeout),
    .cfg_out_en  (cfg_out_en),
    .cfg_rst_en  (cfg_rst_en),
    .key_ok      (key_ok),
    .key_data_q  (key_data_q)
);

// File: tb/tb_keyed_reg_guard.sv
module tb_keyed_reg_guard;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rd_data;
    logic       strap_out_en = 1'b1;
    logic       wdt_timeout = 1'b0;
    logic       cfg_out_en;
    logic       cfg_rst_en;
    logic       key_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;   // 0: read data, 1: {out_en, rst_en, key_ok} pins
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    keyed_reg_guard dut (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rd_data  (bus_rd_data),
        .strap_out_en (strap_out_en),
        .wdt_timeout  (wdt_timeout),
        .cfg_out_en   (cfg_out_en),
        .cfg_rst_en   (cfg_rst_en),
        .key_ok       (key_ok)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- driver tasks ----------------
    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic tmo = 1'b0);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; wdt_timeout = tmo;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0; wdt_timeout = 1'b0;
        it.kind = 0; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic check_pins(input logic oe, input logic re, input logic ok, input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_wr = 1'b0; wdt_timeout = 1'b0;
        it.kind = 1; it.exp = {5'b0, oe, re, ok}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst = 1'b1; strap_out_en = strap; bus_wr = 1'b0; wdt_timeout = 1'b0;
        @(negedge clk);
        rst = 1'b0; strap_out_en = ~strap;   // later strap changes must not matter
    endtask

    task automatic send_pattern();
        do_write(8'h03, 8'h32);
        do_write(8'h03, 8'h5D);
        do_write(8'h03, 8'h42);
        do_write(8'h03, 8'hAC);
    endtask

    // ---------------- monitor ----------------
    initial begin
        forever begin
            logic [7:0] act;
            sb_item_t   it;
            @(negedge clk);
            #(CLK_PERIOD / 4);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                act = (it.kind == 0) ? bus_rd_data : {5'b0, cfg_out_en, cfg_rst_en, key_ok};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        // R1: reset state with strap high
        do_reset(1'b1);
        do_read(8'h00, 8'h81, "R1 cfg after reset, strap=1");
        do_read(8'h03, 8'hF3, "R1 key data reset value");
        do_read(8'h02, 8'h00, "R1 status after reset");
        check_pins(1'b1, 1'b1, 1'b0, "R1 pins after reset");

        // R6: locked write ignored
        do_write(8'h00, 8'h00);
        do_read(8'h00, 8'h81, "R6 locked cfg write ignored");

        // R8: key readback
        do_write(8'h03, 8'h77);
        do_read(8'h03, 8'h77, "R8 key data readback");

        // R3: broken pattern does not unlock
        do_write(8'h03, 8'h32);
        do_write(8'h03, 8'h5D);
        do_write(8'h03, 8'h42);
        do_write(8'h03, 8'h11);
        do_write(8'h03, 8'hAC);
        do_read(8'h02, 8'h00, "R3 broken pattern stays locked");

        // R3: repeated first byte restarts as first byte
        do_write(8'h03, 8'h32);
        send_pattern();
        do_read(8'h02, 8'h40, "R3 0x32 restart counted, R2 unlock");
        check_pins(1'b1, 1'b1, 1'b1, "R2 key_ok pin");

        // R5: relock
        do_write(8'h03, 8'h35);
        do_read(8'h02, 8'h00, "R5 relock byte clears");
        do_read(8'h03, 8'h35, "R8 relock byte readback");

        // R5: relock byte while locked has no effect
        do_write(8'h03, 8'h35);
        do_read(8'h02, 8'h00, "R5 relock while locked stays locked");

        // R4: interleaved writes to other offsets
        do_write(8'h03, 8'h32);
        do_write(8'h00, 8'h00);
        do_write(8'h03, 8'h5D);
        do_write(8'h01, 8'hFF);
        do_write(8'h03, 8'h42);
        do_write(8'h02, 8'h00);
        do_write(8'h03, 8'hAC);
        do_read(8'h02, 8'h40, "R4 interleaved writes keep progress");
        do_read(8'h00, 8'h81, "R6 cfg write during pattern ignored");

        // R6: unlocked writes land, only bits 7 and 0
        do_write(8'h00, 8'h80);
        do_read(8'h00, 8'h80, "R6 unlocked cfg write");
        do_write(8'h00, 8'h7E);
        do_read(8'h00, 8'h00, "R6 only bits 7 and 0 writable");

        // R5: stays open on other bytes and repeated pattern
        send_pattern();
        do_read(8'h02, 8'h40, "R5 repeated pattern keeps open");
        do_write(8'h03, 8'h11);
        do_read(8'h02, 8'h40, "R5 other byte keeps open");

        // R9: unmapped offsets
        do_read(8'h01, 8'h00, "R9 unmapped offset 0x01");
        do_read(8'h05, 8'h00, "R9 unmapped offset 0x05");

        // R7: timeout beats simultaneous write
        do_write(8'h00, 8'h81);
        do_read(8'h00, 8'h81, "R6 unlocked cfg write 0x81");
        do_write(8'h00, 8'h81, 1'b1);
        do_read(8'h00, 8'h00, "R7 timeout wins over write");
        check_pins(1'b0, 1'b0, 1'b1, "R7 pins after timeout");

        // R10: reset while open, strap low, partial progress dropped
        do_write(8'h03, 8'h32);
        do_reset(1'b0);
        do_read(8'h02, 8'h00, "R10 reset relocks");
        do_read(8'h00, 8'h01, "R1 cfg after reset, strap=0");
        do_read(8'h03, 8'hF3, "R1 key data after second reset");
        do_write(8'h03, 8'h32);
        do_write(8'h03, 8'h5D);
        do_reset(1'b0);
        do_write(8'h03, 8'h42);
        do_write(8'h03, 8'hAC);
        do_read(8'h02, 8'h00, "R10 partial progress discarded");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule